// File: doc/BRIEF.md
# Per-CPU Soft Interrupt Combiner

This block keeps the interrupt pending word of a single processor and turns it into level requests for that processor. The pending word holds two kinds of bits. Bits 1 to 15 are hardware level bits, and they follow the events that arrive on a set/clear strobe and on a local timer input. Bits 17 to 31 are software interrupt bits, and software sets or clears them through a small word-addressed register port. Bit 0 and bit 16 are never used.

On every cycle the block combines the software bits, moved down by 16 so that they land on levels 1 to 15, with the 15-bit level vector that an external router delivers for this processor. The result is a registered level-request vector. The block also produces a registered 4-bit code that names the highest level requested. A processor core samples these two outputs and takes its interrupt from them. Software can read the whole pending word back through the same register port.

Top module: `irqc_cpu_combiner`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, the pending word is zero and `lvl_vec`, `lvl_code` and `rd_data` are all zero.
- R2: `rd_data` is registered. In the cycle after word address `addr` is presented, it holds the pending word as it stood when the address was sampled if `addr` is 0, and zero for any other address.
- R3: A write to word address 2 ORs `wr_data & 32'hFFFE0000` into the pending word.
- R4: A write to word address 1 first adds bit 31 to the data if data bit 14 is set. It then clears the pending bits given by `data & 32'hFFFE0000`. A write of only bit 14 therefore clears software bit 31.
- R5: Writes to word addresses 0 and 3 leave the pending word unchanged.
- R6: A pulse on `hw_stb` writes `hw_set` into pending bit `hw_level`. A `hw_level` of 0 is ignored.
- R7: A rising edge on `timer_in` sets pending bit TIMER_LEVEL (default 10), and a falling edge clears it. If a hardware strobe hits the same bit in the same cycle, the timer edge wins.
- R8: `lvl_vec[i]`, which stands for level i+1, equals `sys_levels[i] | pending[i+17]`. It is registered and reflects the inputs and writes of the previous cycle.
- R9: `lvl_code` is the number (1 to 15) of the highest set bit position plus one in the same registered vector, or 0 when the vector is empty. Level 15 has the highest priority.
- R10: A software write and a hardware strobe in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write enable |
| addr | input | 2 | Register word address |
| wr_data | input | 32 | Register write data |
| rd_data | output | 32 | Registered read data |
| sys_levels | input | 15 | Routed system levels, bit i is level i+1 |
| hw_stb | input | 1 | Hardware level set/clear strobe |
| hw_set | input | 1 | 1 sets, 0 clears the strobed bit |
| hw_level | input | 4 | Level number for the strobe |
| timer_in | input | 1 | Local timer interrupt level |
| lvl_vec | output | 15 | Registered level-request vector |
| lvl_code | output | 4 | Registered highest requested level |

## Verification
The assertions assume that `timer_in` and `hw_stb` target different bits, or else that a timer edge takes precedence. They also assume that `hw_level` never makes the hardware path reach the software field. Both hold because a level number of at most 15 cannot touch bits 17 to 31. The random stimulus draws `hw_level` over all 16 codes, including the ignored 0. It toggles `timer_in` only now and then, so edges stay isolated. It spreads address and data across all four offsets. Directed cases cover the clear quirk, collisions between the timer and a strobe, and writes and strobes in the same cycle.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int WORD_W     = 32;
  localparam int NUM_LVL    = 15;
  localparam int CODE_W     = 4;
  localparam int ADDR_W     = 2;
  localparam int SOFT_LSB   = 17;
  localparam int SOFT_SHIFT = 16;
  localparam int QUIRK_BIT  = 14;
  localparam logic [WORD_W-1:0] SOFT_MASK = 32'hFFFE_0000;

  typedef enum logic [ADDR_W-1:0] {
    A_READ  = 2'd0,
    A_CLEAR = 2'd1,
    A_SET   = 2'd2,
    A_NONE  = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/irqc_pend_reg.sv
module irqc_pend_reg
  import irqc_pkg::*;
#(
  parameter int TIMER_LEVEL = 10
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [WORD_W-1:0]    wr_data,
  input  logic                 hw_stb,
  input  logic                 hw_set,
  input  logic [CODE_W-1:0]    hw_level,
  input  logic                 timer_in,
  output logic [WORD_W-1:0]    pend_q,
  output logic [WORD_W-1:0]    pend_nxt
);
  logic              timer_q;
  logic              tmr_rise, tmr_fall;
  logic [WORD_W-1:0] clr_bits;

  assign tmr_rise = timer_in & ~timer_q;
  assign tmr_fall = ~timer_in & timer_q;

  always_comb begin
    clr_bits = wr_data;
    if (wr_data[QUIRK_BIT]) clr_bits[WORD_W-1] = 1'b1;
    clr_bits = clr_bits & SOFT_MASK;
  end

  always_comb begin
    pend_nxt = pend_q;
    if (wr_en && addr == A_CLEAR) pend_nxt = pend_nxt & ~clr_bits;
    if (wr_en && addr == A_SET)   pend_nxt = pend_nxt | (wr_data & SOFT_MASK);
    if (hw_stb && hw_level != '0) pend_nxt[hw_level] = hw_set;
    if (tmr_rise) pend_nxt[TIMER_LEVEL] = 1'b1;
    if (tmr_fall) pend_nxt[TIMER_LEVEL] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q  <= '0;
      timer_q <= 1'b0;
    end else begin
      pend_q  <= pend_nxt;
      timer_q <= timer_in;
    end
  end

  // R3
  set_write_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == A_SET) |=>
      ((pend_q & $past(wr_data) & SOFT_MASK) == ($past(wr_data) & SOFT_MASK)));

  // R4
  clear_write_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == A_CLEAR) |=>
      (((pend_q & $past(wr_data) & SOFT_MASK) == '0) &&
       !($past(wr_data[QUIRK_BIT]) && pend_q[WORD_W-1])));

  // R5
  ignored_write_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (addr == A_READ || addr == A_NONE)) |=>
      ((pend_q & SOFT_MASK) == ($past(pend_q) & SOFT_MASK)));

  // R6
  hw_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    (hw_stb && hw_level != '0 && !((tmr_rise || tmr_fall) && hw_level == TIMER_LEVEL)) |=>
      (pend_q[$past(hw_level)] == $past(hw_set)));

  // R7
  timer_edge_chk: assert property (@(posedge clk) disable iff (rst)
    (timer_in != timer_q) |=> (pend_q[TIMER_LEVEL] == $past(timer_in)));
endmodule

// File: rtl/irqc_prio_enc.sv
module irqc_prio_enc
  import irqc_pkg::*;
#(
  parameter int N = NUM_LVL,
  parameter int W = CODE_W
) (
  input  logic [N-1:0] vec,
  output logic [W-1:0] code
);
  always_comb begin
    code = '0;
    for (int i = 0; i < N; i++) begin
      if (vec[i]) code = W'(i + 1);
    end
  end
endmodule

// File: rtl/irqc_cpu_combiner.sv
module irqc_cpu_combiner
  import irqc_pkg::*;
#(
  parameter int TIMER_LEVEL = 10
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [WORD_W-1:0]    wr_data,
  output logic [WORD_W-1:0]    rd_data,
  input  logic [NUM_LVL-1:0]   sys_levels,
  input  logic                 hw_stb,
  input  logic                 hw_set,
  input  logic [CODE_W-1:0]    hw_level,
  input  logic                 timer_in,
  output logic [NUM_LVL-1:0]   lvl_vec,
  output logic [CODE_W-1:0]    lvl_code
);
  logic [WORD_W-1:0]  pend_q, pend_nxt;
  logic [NUM_LVL-1:0] vec_nxt;
  logic [CODE_W-1:0]  code_nxt;

  irqc_pend_reg #(.TIMER_LEVEL(TIMER_LEVEL)) u_pend (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .hw_stb(hw_stb), .hw_set(hw_set), .hw_level(hw_level),
    .timer_in(timer_in), .pend_q(pend_q), .pend_nxt(pend_nxt)
  );

  assign vec_nxt = sys_levels | pend_nxt[WORD_W-1:SOFT_LSB];

  irqc_prio_enc #(.N(NUM_LVL), .W(CODE_W)) u_enc (
    .vec(vec_nxt), .code(code_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_vec  <= '0;
      lvl_code <= '0;
      rd_data  <= '0;
    end else begin
      lvl_vec  <= vec_nxt;
      lvl_code <= code_nxt;
      rd_data  <= (addr == A_READ) ? pend_q : '0;
    end
  end

  // R8
  vec_merge_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (lvl_vec == ($past(sys_levels) | pend_q[WORD_W-1:SOFT_LSB])));

  // R9
  code_empty_chk: assert property (@(posedge clk) disable iff (rst)
    ((lvl_vec == '0) == (lvl_code == '0)));

  // R9
  code_top_chk: assert property (@(posedge clk) disable iff (rst)
    (lvl_code != '0) |-> (lvl_vec[lvl_code - 1'b1] && ((lvl_vec >> lvl_code) == '0)));

  // R2
  read_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (addr != A_READ) |=> (rd_data == '0));
endmodule

// File: tb/irqc_cpu_combiner_bench.sv
module irqc_cpu_combiner_bench;
  localparam int TL = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  addr = 2'd3;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic [14:0] sys_levels = '0;
  logic        hw_stb = 1'b0, hw_set = 1'b0;
  logic [3:0]  hw_level = '0;
  logic        timer_in = 1'b0;
  logic [14:0] lvl_vec;
  logic [3:0]  lvl_code;

  int errors = 0, checks = 0;
  bit done = 0;
  logic [31:0] m_pend = '0;
  logic        m_tm = 1'b0;

  always #5 clk = ~clk;

  irqc_cpu_combiner #(.TIMER_LEVEL(TL)) u_irqc_cpu_combiner (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .sys_levels(sys_levels), .hw_stb(hw_stb),
    .hw_set(hw_set), .hw_level(hw_level), .timer_in(timer_in),
    .lvl_vec(lvl_vec), .lvl_code(lvl_code)
  );

  function automatic logic [3:0] top_level(input logic [14:0] v);
    logic [3:0] c = '0;
    for (int i = 0; i < 15; i++) if (v[i]) c = 4'(i + 1);
    return c;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One clock: drive at negedge, compare at next negedge against the model.
  task automatic cycle(input logic we, input logic [1:0] a, input logic [31:0] d,
                       input logic hs, input logic hset, input logic [3:0] hl,
                       input logic tm, input logic [14:0] sys);
    logic [31:0] nxt, c, exp_rd;
    logic [14:0] exp_vec;
    wr_en = we; addr = a; wr_data = d; hw_stb = hs; hw_set = hset;
    hw_level = hl; timer_in = tm; sys_levels = sys;
    exp_rd = (a == 2'd0) ? m_pend : 32'h0;
    nxt = m_pend;
    if (we && a == 2'd1) begin
      c = d; if (d[14]) c[31] = 1'b1;
      nxt = nxt & ~(c & 32'hFFFE_0000);
    end
    if (we && a == 2'd2) nxt = nxt | (d & 32'hFFFE_0000);
    if (hs && hl != 4'd0) nxt[hl] = hset;
    if (tm && !m_tm) nxt[TL] = 1'b1;
    if (!tm && m_tm) nxt[TL] = 1'b0;
    m_tm = tm; m_pend = nxt;
    exp_vec = sys | nxt[31:17];
    @(negedge clk);
    chk("R8 vec", 32'(lvl_vec), 32'(exp_vec));
    chk("R9 code", 32'(lvl_code), 32'(top_level(exp_vec)));
    chk("R2 read", rd_data, exp_rd);
  endtask

  task automatic rd0(input string tag, input logic [31:0] exp);
    cycle(0, 2'd0, 0, 0, 0, 0, m_tm, 0);
    chk(tag, rd_data, exp);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk("R1 vec", 32'(lvl_vec), 0);
    chk("R1 code", 32'(lvl_code), 0);
    chk("R1 rd", rd_data, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 after", 32'(lvl_vec), 0);
    rd0("R1 pend", 32'h0);

    cycle(1, 2'd2, 32'hFFFF_FFFF, 0, 0, 0, 0, 0);
    chk("R9 top15", 32'(lvl_code), 32'd15);
    rd0("R3 set", 32'hFFFE_0000);
    cycle(1, 2'd1, 32'h0000_4000, 0, 0, 0, 0, 0);
    rd0("R4 quirk", 32'h7FFE_0000);
    cycle(1, 2'd1, 32'hFFFE_0000, 0, 0, 0, 0, 0);
    rd0("R4 clear", 32'h0);
    cycle(1, 2'd3, 32'hFFFF_FFFF, 0, 0, 0, 0, 0);
    cycle(1, 2'd0, 32'hFFFF_FFFF, 0, 0, 0, 0, 0);
    rd0("R5 ignored", 32'h0);
    cycle(1, 2'd2, 32'h0002_0000, 0, 0, 0, 0, 0);
    cycle(0, 2'd3, 0, 0, 0, 0, 0, 0);
    chk("R2 addr3", rd_data, 32'h0);
    cycle(1, 2'd2, 32'h0010_0000, 1, 1, 4'd5, 0, 0);
    cycle(0, 2'd3, 0, 1, 1, 4'd0, 0, 0);
    rd0("R10 R6 both", 32'h0012_0020);
    cycle(0, 2'd3, 0, 0, 0, 0, 1, 0);
    rd0("R7 rise", 32'h0012_0420);
    cycle(0, 2'd3, 0, 1, 1, 4'd10, 0, 0);
    rd0("R7 fall wins", 32'h0012_0020);
    cycle(0, 2'd3, 0, 0, 0, 0, 0, 15'h0001);
    chk("R8 merge", 32'(lvl_vec), 32'h9);
    chk("R9 code4", 32'(lvl_code), 32'd4);

    for (int n = 0; n < 3000; n++) begin
      logic tm;
      logic [14:0] sys;
      tm = (($urandom % 8) == 0) ? ~m_tm : m_tm;
      sys = (($urandom % 2) == 0) ? 15'(($urandom % 2 == 0) ? (1 << ($urandom % 15)) : 0) : 15'h0;
      cycle(1'($urandom % 2), 2'($urandom % 4), $urandom,
            (($urandom % 4) == 0), 1'($urandom % 2), 4'($urandom % 16), tm, sys);
    end

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule